// File: doc/BRIEF.md
# Multicast Row/Column Addressed Load Bus

This block moves wide payload packets from a shared buffer into a grid of processing elements in a single cycle. Each packet carries a payload, a one-bit kind tag (input-activation or weight) and two address fields: a row key and a column key. Every grid row holds a programmable row key and every element holds a programmable column key. A packet lands in every element whose row key matches the packet's row field and whose own column key matches the packet's column field. One packet can therefore reach a single element, a full row, a diagonal, or any other pattern the keys describe.

The packet input is a valid/ready stream. The producer raises `in_valid` with a stable packet and keeps it stable until `in_ready` is seen high at a rising edge. `in_ready` is computed in the same cycle from the presented header and the elements' free flags. It drops whenever any addressed element has its target buffer occupied, and the producer must not make `in_valid` depend on `in_ready`. When a handshake occurs, the payload and per-element load strobes appear combinationally in that cycle, and the elements capture on the same edge. Keys are written through a plain configuration port before a layer starts. By default the grid is 15 rows by 16 columns, with a 256-bit payload.

Top module: `pe_mcast_bus`

## Requirements
- R1: After reset, row r holds row key r and the element in column c holds column key c, so a packet with row field r and column field c reaches only element (r,c).
- R2: On a handshake, every element whose row's key equals `in_row_id` and whose own key equals `in_col_id` is loaded in that same cycle, and no other element is loaded.
- R3: Kind 0 drives only `pe_load_act` and kind 1 drives only `pe_load_wgt`. No element sees both strobes in one cycle.
- R4: `in_ready` is low exactly when at least one addressed element reports its target buffer (activation for kind 0, weight for kind 1) not free. While it is low, no strobe is raised. Free flags of elements that are not addressed, and free flags of the other buffer kind, have no effect.
- R5: A packet that addresses no element is accepted (`in_ready` high) and loads nothing.
- R6: With `cfg_we` high at a rising edge, `cfg_kind`=0 writes `cfg_id` into the row key of row `cfg_row`, and `cfg_kind`=1 writes it into the column key of element (`cfg_row`,`cfg_col`). The new key steers packets from the following cycle on, and before that edge the old key still applies.
- R7: A configuration write whose `cfg_row` is not below ROWS, or (for kind 1) whose `cfg_col` is not below COLS, changes no key.
- R8: Bit r*COLS+c of `deliver_mask` is high exactly when element (r,c) is loaded this cycle. The mask is zero when no handshake takes place.
- R9: `pe_data` carries `in_data` in every cycle in which any element is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Key write strobe |
| cfg_kind | input | 1 | 0: row key write, 1: element column key write |
| cfg_row | input | clog2(ROWS) | Target row of a key write |
| cfg_col | input | clog2(COLS) | Target column of an element key write |
| cfg_id | input | ID_W | Key value to write |
| in_valid | input | 1 | Packet present |
| in_ready | output | 1 | Packet accepted this cycle if valid |
| in_kind | input | 1 | 0: activation buffer, 1: weight buffer |
| in_row_id | input | ID_W | Row field of the packet |
| in_col_id | input | ID_W | Column field of the packet |
| in_data | input | DATA_W | Payload |
| pe_act_free | input | ROWS*COLS | Per-element activation buffer free flag |
| pe_wgt_free | input | ROWS*COLS | Per-element weight buffer free flag |
| pe_data | output | DATA_W | Payload broadcast to all elements |
| pe_load_act | output | ROWS*COLS | Per-element activation load strobe |
| pe_load_wgt | output | ROWS*COLS | Per-element weight load strobe |
| deliver_mask | output | ROWS*COLS | Elements loaded this cycle |

## Verification
The bench builds the bus with ROWS=3, COLS=3, ID_W=3 and DATA_W=16. This keeps every delivery mask nine bits wide, so it can be written out and reasoned about by hand. Because three rows and three columns leave index 3 unused in each 2-bit configuration index, out-of-range writes can be exercised. A 3-bit key leaves values that no row or element holds after reset, which gives packets that match nothing. The small grid also lets a whole row, a full anti-diagonal and single-element stalls be set up with a handful of key writes.

// File: rtl/pe_bus_pkg.sv
package pe_bus_pkg;

  typedef enum logic {
    KIND_ACT = 1'b0,
    KIND_WGT = 1'b1
  } pkt_kind_e;

  typedef enum logic {
    CFG_ROW_KEY  = 1'b0,
    CFG_ELEM_KEY = 1'b1
  } cfg_kind_e;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/pe_bus_row_node.sv
module pe_bus_row_node #(
  parameter int ROW_IDX = 0,
  parameter int ID_W    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_hit,
  input  logic [ID_W-1:0] cfg_id,
  input  logic [ID_W-1:0] pkt_row,
  output logic            row_hit
);
  localparam logic [ID_W-1:0] RST_KEY = ID_W'(ROW_IDX);

  logic [ID_W-1:0] key_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       key_q <= RST_KEY;
    else if (cfg_hit) key_q <= cfg_id;
  end

  assign row_hit = (key_q == pkt_row);
endmodule

// File: rtl/pe_bus_elem_node.sv
module pe_bus_elem_node
  import pe_bus_pkg::*;
#(
  parameter int COL_IDX = 0,
  parameter int ID_W    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_hit,
  input  logic [ID_W-1:0] cfg_id,
  input  logic            row_hit,
  input  logic [ID_W-1:0] pkt_col,
  input  pkt_kind_e       pkt_kind,
  input  logic            act_free,
  input  logic            wgt_free,
  output logic            sel,
  output logic            blocked
);
  localparam logic [ID_W-1:0] RST_KEY = ID_W'(COL_IDX);

  logic [ID_W-1:0] key_q;
  logic            tgt_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       key_q <= RST_KEY;
    else if (cfg_hit) key_q <= cfg_id;
  end

  assign sel      = row_hit && (key_q == pkt_col);
  assign tgt_free = (pkt_kind == KIND_ACT) ? act_free : wgt_free;
  assign blocked  = sel && !tgt_free;
endmodule

// File: rtl/pe_mcast_bus.sv
module pe_mcast_bus
  import pe_bus_pkg::*;
#(
  parameter int ROWS   = 15,
  parameter int COLS   = 16,
  parameter int ID_W   = 4,
  parameter int DATA_W = 256,
  localparam int RIX_W = idx_w(ROWS),
  localparam int CIX_W = idx_w(COLS),
  localparam int NPE   = ROWS * COLS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_kind,
  input  logic [RIX_W-1:0]  cfg_row,
  input  logic [CIX_W-1:0]  cfg_col,
  input  logic [ID_W-1:0]   cfg_id,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_kind,
  input  logic [ID_W-1:0]   in_row_id,
  input  logic [ID_W-1:0]   in_col_id,
  input  logic [DATA_W-1:0] in_data,
  input  logic [NPE-1:0]    pe_act_free,
  input  logic [NPE-1:0]    pe_wgt_free,
  output logic [DATA_W-1:0] pe_data,
  output logic [NPE-1:0]    pe_load_act,
  output logic [NPE-1:0]    pe_load_wgt,
  output logic [NPE-1:0]    deliver_mask
);
  pkt_kind_e       kind;
  cfg_kind_e       ckind;
  logic [ROWS-1:0] row_hit;
  logic [NPE-1:0]  sel;
  logic [NPE-1:0]  blocked;
  logic            fire;

  assign kind  = pkt_kind_e'(in_kind);
  assign ckind = cfg_kind_e'(cfg_kind);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic row_cfg_hit;
    assign row_cfg_hit = cfg_we && (ckind == CFG_ROW_KEY) &&
                         (cfg_row == RIX_W'(r));

    pe_bus_row_node #(.ROW_IDX(r), .ID_W(ID_W)) u_row (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_hit (row_cfg_hit),
      .cfg_id  (cfg_id),
      .pkt_row (in_row_id),
      .row_hit (row_hit[r])
    );

    for (genvar c = 0; c < COLS; c++) begin : g_col
      logic elem_cfg_hit;
      assign elem_cfg_hit = cfg_we && (ckind == CFG_ELEM_KEY) &&
                            (cfg_row == RIX_W'(r)) && (cfg_col == CIX_W'(c));

      pe_bus_elem_node #(.COL_IDX(c), .ID_W(ID_W)) u_elem (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_hit  (elem_cfg_hit),
        .cfg_id   (cfg_id),
        .row_hit  (row_hit[r]),
        .pkt_col  (in_col_id),
        .pkt_kind (kind),
        .act_free (pe_act_free[r*COLS+c]),
        .wgt_free (pe_wgt_free[r*COLS+c]),
        .sel      (sel[r*COLS+c]),
        .blocked  (blocked[r*COLS+c])
      );
    end
  end

  // Accept only when no addressed element is full for this packet kind.
  assign in_ready     = ~|blocked;
  assign fire         = in_valid && in_ready;
  assign deliver_mask = fire ? sel : '0;
  assign pe_load_act  = (kind == KIND_ACT) ? deliver_mask : '0;
  assign pe_load_wgt  = (kind == KIND_WGT) ? deliver_mask : '0;
  assign pe_data      = in_data;
endmodule

// File: rtl/pe_mcast_bus_chk.sv
module pe_mcast_bus_chk #(
  parameter int NPE    = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_kind,
  input logic [DATA_W-1:0] in_data,
  input logic [NPE-1:0]    pe_act_free,
  input logic [NPE-1:0]    pe_wgt_free,
  input logic [DATA_W-1:0] pe_data,
  input logic [NPE-1:0]    pe_load_act,
  input logic [NPE-1:0]    pe_load_wgt,
  input logic [NPE-1:0]    deliver_mask
);
  a_r3_one_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_load_act & pe_load_wgt) == '0);

  a_r3_kind_act: assert property (@(posedge clk) disable iff (!rst_n)
    !in_kind |-> pe_load_wgt == '0);

  a_r3_kind_wgt: assert property (@(posedge clk) disable iff (!rst_n)
    in_kind |-> pe_load_act == '0);

  a_r4_act_free: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_load_act & ~pe_act_free) == '0);

  a_r4_wgt_free: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_load_wgt & ~pe_wgt_free) == '0);

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |-> (deliver_mask == '0 && pe_load_act == '0 && pe_load_wgt == '0));

  a_r8_mask_union: assert property (@(posedge clk) disable iff (!rst_n)
    deliver_mask == (pe_load_act | pe_load_wgt));

  a_r9_payload: assert property (@(posedge clk) disable iff (!rst_n)
    (|deliver_mask) |-> pe_data == in_data);
endmodule

bind pe_mcast_bus pe_mcast_bus_chk #(.NPE(ROWS*COLS), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_kind      (in_kind),
  .in_data      (in_data),
  .pe_act_free  (pe_act_free),
  .pe_wgt_free  (pe_wgt_free),
  .pe_data      (pe_data),
  .pe_load_act  (pe_load_act),
  .pe_load_wgt  (pe_load_wgt),
  .deliver_mask (deliver_mask)
);

// File: tb/pe_mcast_bus_test.sv
module pe_mcast_bus_test;
  localparam int ROWS = 3, COLS = 3, ID_W = 3, DW = 16, N = 9;

  logic          clk = 0, rst_n = 0;
  logic          cfg_we = 0, cfg_kind = 0;
  logic [1:0]    cfg_row = 0, cfg_col = 0;
  logic [2:0]    cfg_id = 0;
  logic          in_valid = 0, in_kind = 0;
  logic [2:0]    in_row_id = 0, in_col_id = 0;
  logic [DW-1:0] in_data = 0;
  logic [N-1:0]  act_free = '1, wgt_free = '1;
  logic          in_ready;
  logic [DW-1:0] pe_data;
  logic [N-1:0]  ld_act, ld_wgt, mask;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_row [ROWS];
  int m_col [N];

  always #5 clk = ~clk;

  pe_mcast_bus #(.ROWS(ROWS), .COLS(COLS), .ID_W(ID_W), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_row(cfg_row), .cfg_col(cfg_col), .cfg_id(cfg_id),
    .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind),
    .in_row_id(in_row_id), .in_col_id(in_col_id), .in_data(in_data),
    .pe_act_free(act_free), .pe_wgt_free(wgt_free), .pe_data(pe_data),
    .pe_load_act(ld_act), .pe_load_wgt(ld_wgt), .deliver_mask(mask)
  );

  // kind, row, col, act_free, wgt_free, exp_ready, exp_mask (reset keys)
  localparam int VW = 35;
  localparam logic [VW-1:0] VEC [8] = '{
    {1'b0, 3'd0, 3'd0, 9'h1FF, 9'h1FF, 1'b1, 9'h001},
    {1'b1, 3'd2, 3'd1, 9'h1FF, 9'h1FF, 1'b1, 9'h080},
    {1'b0, 3'd1, 3'd2, 9'h1DF, 9'h1FF, 1'b0, 9'h000},
    {1'b1, 3'd1, 3'd2, 9'h1DF, 9'h1FF, 1'b1, 9'h020},
    {1'b0, 3'd2, 3'd2, 9'h1FE, 9'h1FF, 1'b1, 9'h100},
    {1'b0, 3'd3, 3'd0, 9'h1FF, 9'h1FF, 1'b1, 9'h000},
    {1'b1, 3'd0, 3'd7, 9'h1FF, 9'h1FF, 1'b1, 9'h000},
    {1'b1, 3'd1, 3'd1, 9'h1FF, 9'h000, 1'b0, 9'h000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] model_sel();
    logic [N-1:0] s = '0;
    for (int e = 0; e < N; e++)
      s[e] = (m_row[e / COLS] == int'(in_row_id)) && (m_col[e] == int'(in_col_id));
    return s;
  endfunction

  // Checks the present outputs against the model for the driven inputs.
  task automatic check_now(input string req);
    logic [N-1:0] s = model_sel();
    logic [N-1:0] fr = in_kind ? wgt_free : act_free;
    logic rdy = ((s & ~fr) == '0);
    logic [N-1:0] m = (rdy && in_valid) ? s : '0;
    check({req, " ready"}, 32'(in_ready), 32'(rdy));
    check({req, " mask"}, 32'(mask), 32'(m));
    check({req, " act"}, 32'(ld_act), in_kind ? 32'(0) : 32'(m));
    check({req, " wgt"}, 32'(ld_wgt), in_kind ? 32'(m) : 32'(0));
  endtask

  task automatic cfg_write(input logic k, input int r, input int c, input int id);
    @(negedge clk);
    cfg_we = 1; cfg_kind = k; cfg_row = 2'(r); cfg_col = 2'(c); cfg_id = 3'(id);
    @(negedge clk);
    cfg_we = 0;
    if (r < ROWS) begin
      if (!k) m_row[r] = id;
      else if (c < COLS) m_col[r*COLS+c] = id;
    end
  endtask

  task automatic send(input logic k, input int r, input int c,
                      input logic [N-1:0] af, input logic [N-1:0] wf, input string req);
    @(negedge clk);
    in_valid = 1; in_kind = k; in_row_id = 3'(r); in_col_id = 3'(c);
    act_free = af; wgt_free = wf; in_data = in_data + 16'h0101;
    #1;
    check_now(req);
    if (|mask) check({req, " data"}, 32'(pe_data), 32'(in_data));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < ROWS; r++) m_row[r] = r;
    for (int e = 0; e < N; e++) m_col[e] = e % COLS;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R8: idle bus loads nothing
    check("R8 idle mask", 32'(mask), 0);
    check("R8 idle ready", 32'(in_ready), 1);

    // R1 R3 R4 R5 R9: table walk over reset keys
    for (int i = 0; i < 8; i++) begin
      logic [VW-1:0] v = VEC[i];
      @(negedge clk);
      in_valid = 1; in_kind = v[34]; in_row_id = v[33:31]; in_col_id = v[30:28];
      act_free = v[27:19]; wgt_free = v[18:10]; in_data = 16'hA000 + 16'(i);
      #1;
      check("R4 ready", 32'(in_ready), 32'(v[9]));
      check("R1 mask", 32'(mask), 32'(v[8:0]));
      check("R3 act", 32'(ld_act), v[34] ? 32'(0) : 32'(v[8:0]));
      check("R3 wgt", 32'(ld_wgt), v[34] ? 32'(v[8:0]) : 32'(0));
      if (|v[8:0]) check("R9 data", 32'(pe_data), 32'(in_data));
    end
    @(negedge clk); in_valid = 0; act_free = '1; wgt_free = '1;
    #1 check("R8 valid low", 32'(mask), 0);

    // R2: whole-row sharing with all column keys zero
    for (int e = 0; e < N; e++) cfg_write(1'b1, e / COLS, e % COLS, 0);
    send(1'b1, 1, 0, '1, '1, "R2 row");
    check("R2 row hand", 32'(mask), 32'h038);

    // R2 R6: anti-diagonal sharing, all row keys zero, column key r+c
    for (int r = 0; r < ROWS; r++) cfg_write(1'b0, r, 0, 0);
    for (int e = 0; e < N; e++) cfg_write(1'b1, e / COLS, e % COLS, e / COLS + e % COLS);
    send(1'b0, 0, 2, '1, '1, "R2 diag");
    check("R2 diag hand", 32'(mask), 32'h054);
    // R4: one blocked diagonal element stalls the whole multicast
    send(1'b0, 0, 2, 9'h1EF, '1, "R4 diag stall");

    // R6: write takes effect only after its edge
    @(negedge clk);
    cfg_we = 1; cfg_kind = 0; cfg_row = 0; cfg_id = 5;
    in_valid = 1; in_kind = 0; in_row_id = 5; in_col_id = 0; act_free = '1; wgt_free = '1;
    #1 check_now("R6 before edge");
    @(negedge clk);
    cfg_we = 0; m_row[0] = 5;
    #1 check_now("R6 after edge");
    check("R6 after hand", 32'(mask), 32'h001);

    // R7: out-of-range writes change nothing
    cfg_write(1'b0, 3, 0, 6);
    cfg_write(1'b1, 0, 3, 6);
    cfg_write(1'b1, 3, 0, 6);
    send(1'b0, 6, 0, '1, '1, "R7 row oob");
    send(1'b1, 0, 1, '1, '1, "R7 col oob");
    check("R7 col hand", 32'(mask), 32'h008);
    send(1'b0, 5, 6, '1, '1, "R7 none");

    // R5: nothing addressed, everything full, still accepted
    send(1'b1, 7, 7, '0, '0, "R5 empty");
    @(negedge clk); in_valid = 0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule